// File: doc/BRIEF.md
# Receive Frame Length Histogram

This block gathers receive-side length statistics for a single Ethernet port. An upstream MAC raises a one-cycle strobe whenever a frame has been fully received. With that strobe it presents the frame's byte count. The block decodes the count in the same cycle and adds one to exactly one of fourteen counters. Twelve of these are histogram bins whose edges follow Ethernet frame classes, including separate bins for single-tagged and double-tagged lengths. The other two catch frames below 64 bytes and frames above 9215 bytes. A fifteenth counter records oversize frames against a programmable maximum length, independently of the histogram.

Software reaches the block through a flat word-addressed register port. It can program the maximum length and read back the fixed minimum length. A write to the command word copies every live counter into read-back registers and clears the live counters in the same cycle, so that consecutive intervals lose no frame. Counters saturate rather than wrap.

Top module: `frame_len_hist`

## Requirements
- R1: A strobed frame of length L increments exactly one bin. The bins, by index, are: 0 for L=64, 1 for 65..127, 2 for 128..255, 3 for 256..511, 4 for 512..1023, 5 for 1024..1518, 6 for 1519..1522, 7 for 1523..1548, 8 for 1549..2047, 9 for 2048..4095, 10 for 4096..8191 and 11 for 8192..9215.
- R2: A frame with L below 64 increments counter 12 (undersize) and no bin.
- R3: A frame with L above 9215 increments counter 13 and no bin.
- R4: Counter 14 (oversize) increments for every frame whose L is strictly greater than the programmed maximum length, in addition to that frame's bin or out-of-range counter.
- R5: The configuration word at address 0x00 holds the maximum length in bits 30:16 and reads the fixed minimum length 64 in bits 15:0; bit 31 reads 0. After reset the maximum length is 9600.
- R6: A write to address 0x00 updates the maximum length only when bits 30:16 of the write data lie in 64..16383. Any other value leaves the previous setting in place.
- R7: Each counter is CNT_W bits wide (default 48) and holds at all ones instead of wrapping.
- R8: Writing 1 in bit 0 of address 0x01 copies all live counters into the read-back registers and clears the live counters in the same cycle. A frame strobed in that cycle counts toward the new interval.
- R9: Strobes on consecutive cycles are each counted.
- R10: The read-back value of counter k is at address 0x10+2k (bits 31:0) and at address 0x11+2k (bits 63:32, zero-extended). After reset every read-back register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_vld_i | input | 1 | One-cycle strobe marking a completed received frame |
| frame_len_i | input | 16 | Byte length of the completed frame |
| reg_wr_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Word address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |

## Verification
The snapshot command and a frame strobe can fall on the same clock edge. In that case the frame must miss the interval being captured and appear in the freshly cleared one. The bench provokes this by asserting both in a single cycle after a known set of frames. It then checks that the captured values contain only the earlier frames, and that a second snapshot shows exactly the one colliding frame in its bin. A second collision is a maximum-length rewrite landing between frames. The bench judges it by the oversize count on each side of the new limit.

// File: rtl/frame_len_hist_pkg.sv
package frame_len_hist_pkg;
  localparam int NUM_BINS  = 12;
  localparam int NUM_CNT   = NUM_BINS + 3;
  localparam int IDX_UNDER = NUM_BINS;
  localparam int IDX_OVER  = NUM_BINS + 1;
  localparam int IDX_OVSZ  = NUM_BINS + 2;
  localparam int MIN_LEN   = 64;
  localparam int TOP_LEN   = 9215;
  localparam int MAX_RST   = 9600;
  localparam int MAX_LEGAL = 16383;

  // upper edge of each histogram bin, inclusive
  function automatic int bin_upper(input int b);
    case (b)
      0:       return 64;
      1:       return 127;
      2:       return 255;
      3:       return 511;
      4:       return 1023;
      5:       return 1518;
      6:       return 1522;
      7:       return 1548;
      8:       return 2047;
      9:       return 4095;
      10:      return 8191;
      11:      return 9215;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/len_classifier.sv
module len_classifier
  import frame_len_hist_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MAX_W = 15
) (
  input  logic             vld_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [MAX_W-1:0] max_len_i,
  output logic [NUM_CNT-1:0] inc_o
);
  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    localparam int LO = (b == 0) ? MIN_LEN : bin_upper(b - 1) + 1;
    localparam int HI = bin_upper(b);
    assign inc_o[b] = vld_i && (len_i >= LEN_W'(LO)) && (len_i <= LEN_W'(HI));
  end

  assign inc_o[IDX_UNDER] = vld_i && (len_i < LEN_W'(MIN_LEN));
  assign inc_o[IDX_OVER]  = vld_i && (len_i > LEN_W'(TOP_LEN));
  assign inc_o[IDX_OVSZ]  = vld_i && (len_i > LEN_W'(max_len_i));
endmodule

// File: rtl/hist_counter.sv
module hist_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] live_q, snap_q;
  logic             full;

  assign full   = &live_q;
  assign snap_o = snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      snap_q <= '0;
    end else if (snap_i) begin
      snap_q <= live_q;
      live_q <= inc_i ? CNT_W'(1) : '0;  // strobe in the snapshot cycle opens the new interval
    end else if (inc_i && !full) begin
      live_q <= live_q + CNT_W'(1);
    end
  end

  p_sat_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && full) |=> (&live_q));
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> (live_q >= $past(live_q)));
  p_snap_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (snap_q == $past(live_q)));
  p_snap_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (live_q == CNT_W'($past(inc_i))));
  p_snap_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));
endmodule

// File: rtl/frame_len_hist.sv
module frame_len_hist
  import frame_len_hist_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int MAX_W   = 15;
  localparam int MAX_LSB = 16;
  localparam int IDX_W   = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT0 = ADDR_W'(16);

  logic [MAX_W-1:0]              max_len_q, wr_max;
  logic                          wr_max_ok, snap;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] snap_val;

  assign wr_max    = reg_wdata_i[MAX_LSB +: MAX_W];
  assign wr_max_ok = (wr_max >= MAX_W'(MIN_LEN)) && (wr_max <= MAX_W'(MAX_LEGAL));
  assign snap      = reg_wr_i && (reg_addr_i == A_CMD) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             max_len_q <= MAX_W'(MAX_RST);
    else if (reg_wr_i && (reg_addr_i == A_CFG) && wr_max_ok) max_len_q <= wr_max;
  end

  len_classifier #(.LEN_W(LEN_W), .MAX_W(MAX_W)) i_classifier (
    .vld_i     (frame_vld_i),
    .len_i     (frame_len_i),
    .max_len_i (max_len_q),
    .inc_o     (inc)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    hist_counter #(.CNT_W(CNT_W)) i_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[k]),
      .snap_i (snap),
      .snap_o (snap_val[k])
    );
  end

  // read mux: counter k lives at A_CNT0 + 2k (low word) and +1 (high word)
  logic [ADDR_W-1:0] cnt_off;
  logic [IDX_W-1:0]  cnt_idx;
  logic [63:0]       cnt_ext;

  assign cnt_off = reg_addr_i - A_CNT0;
  assign cnt_idx = cnt_off[ADDR_W-1:1];

  always_comb begin
    cnt_ext = '0;
    for (int k = 0; k < NUM_CNT; k++)
      if (cnt_idx == IDX_W'(k)) cnt_ext = 64'(snap_val[k]);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_CFG)
      reg_rdata_o = {1'b0, max_len_q, 16'(MIN_LEN)};
    else if (reg_addr_i >= A_CNT0 && cnt_idx < IDX_W'(NUM_CNT))
      reg_rdata_o = cnt_off[0] ? cnt_ext[63:32] : cnt_ext[31:0];
  end

  p_one_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |-> ($countones(inc[IDX_OVER:0]) == 1));
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |-> (inc == '0));
  p_max_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_len_q >= MAX_W'(MIN_LEN)) && (max_len_q <= MAX_W'(MAX_LEGAL)));
  p_max_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == A_CFG) |=> $stable(max_len_q));
endmodule

// File: tb/test_frame_len_hist.sv
module test_frame_len_hist;
  localparam int CNT_W = 10;
  localparam int NCNT  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] len = '0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int exp_cnt [NCNT];

  frame_len_hist #(.CNT_W(CNT_W)) i_frame_len_hist (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(vld), .frame_len_i(len),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  always #4 clk = ~clk;

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // bin index from the edges listed in R1..R3
  function automatic int bin_of(input int l);
    int up [12] = '{64, 127, 255, 511, 1023, 1518, 1522, 1548, 2047, 4095, 8191, 9215};
    if (l < 64) return 12;
    if (l > 9215) return 13;
    for (int b = 0; b < 12; b++) if (l <= up[b]) return b;
    return 13;
  endfunction

  int max_model = 9600;

  task automatic note_frame(input int l);
    int b = bin_of(l);
    if (exp_cnt[b] < (1 << CNT_W) - 1) exp_cnt[b]++;
    if (l > max_model && exp_cnt[14] < (1 << CNT_W) - 1) exp_cnt[14]++;
  endtask

  task automatic frame(input int l);
    @(negedge clk);
    vld = 1'b1; len = 16'(l);
    note_frame(l);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic read_cnt(input int k, output longint v);
    logic [31:0] lo, hi;
    reg_read(6'(16 + 2 * k), lo);
    reg_read(6'(17 + 2 * k), hi);
    v = {hi, lo};
  endtask

  task automatic snap_and_check(input string tag);
    longint v;
    reg_write(6'h01, 32'h1);
    for (int k = 0; k < NCNT; k++) begin
      read_cnt(k, v);
      chk($sformatf("%s cnt%0d", tag, k), v, exp_cnt[k]);
      exp_cnt[k] = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    longint v;
    reg_read(6'h00, d);
    chk("R5 reset max", d[30:16], 9600);
    chk("R5 min len", d[15:0], 64);
    chk("R5 bit31", d[31], 0);
    for (int k = 0; k < NCNT; k++) begin
      read_cnt(k, v);
      chk($sformatf("R10 reset cnt%0d", k), v, 0);
    end
  endtask

  task automatic t_bins();
    int lens [] = '{0, 63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518,
                    1519, 1522, 1523, 1548, 1549, 2047, 2048, 4095, 4096, 8191,
                    8192, 9215, 9216, 9600, 9601, 16000, 65535};
    foreach (lens[i]) frame(lens[i]);
    snap_and_check("R1 R2 R3 R4 bins");
  endtask

  task automatic t_maxlen();
    logic [31:0] d;
    reg_write(6'h00, {1'b0, 15'd2000, 16'd0});
    reg_read(6'h00, d);
    chk("R5 write max 2000", d[30:16], 2000);
    reg_write(6'h00, {1'b0, 15'd63, 16'd0});
    reg_read(6'h00, d);
    chk("R6 ignore 63", d[30:16], 2000);
    reg_write(6'h00, {1'b0, 15'd16384, 16'd0});
    reg_read(6'h00, d);
    chk("R6 ignore 16384", d[30:16], 2000);
    reg_write(6'h05, {1'b0, 15'd100, 16'd0});
    reg_read(6'h00, d);
    chk("R6 other addr", d[30:16], 2000);
    reg_write(6'h00, {1'b0, 15'd16383, 16'd0});
    reg_read(6'h00, d);
    chk("R6 accept 16383", d[30:16], 16383);
    reg_write(6'h00, {1'b0, 15'd64, 16'd0});
    reg_read(6'h00, d);
    chk("R6 accept 64", d[30:16], 64);
    max_model = 64;
    frame(64);
    frame(65);
    frame(30);
    snap_and_check("R4 oversize at 64");
    reg_write(6'h00, {1'b0, 15'd9600, 16'd0});
    max_model = 9600;
  endtask

  task automatic t_b2b();
    int lens [] = '{64, 64, 1520, 1530, 40, 9300};
    foreach (lens[i]) begin
      @(negedge clk);
      vld = 1'b1; len = 16'(lens[i]);
      note_frame(lens[i]);
    end
    @(negedge clk);
    vld = 1'b0;
    snap_and_check("R9 back to back");
  endtask

  task automatic t_same_cycle();
    longint v;
    frame(200);
    frame(200);
    @(negedge clk);
    vld = 1'b1; len = 16'd64;
    wr = 1'b1; addr = 6'h01; wdata = 32'h1;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
    read_cnt(2, v);
    chk("R8 captured old interval bin2", v, 2);
    read_cnt(0, v);
    chk("R8 colliding frame excluded", v, 0);
    for (int k = 0; k < NCNT; k++) exp_cnt[k] = 0;
    exp_cnt[0] = 1;
    snap_and_check("R8 new interval");
    snap_and_check("R8 cleared");
  endtask

  task automatic t_sat();
    @(negedge clk);
    vld = 1'b1; len = 16'd64;
    for (int i = 0; i < 1030; i++) begin
      note_frame(64);
      @(negedge clk);
    end
    vld = 1'b0;
    chk("R7 model saturated", exp_cnt[0], 1023);
    snap_and_check("R7 saturate");
    frame(64);
    snap_and_check("R7 restart after clear");
  endtask

  initial begin
    for (int k = 0; k < NCNT; k++) exp_cnt[k] = 0;
    #20 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bins();
    t_maxlen();
    t_b2b();
    t_same_cycle();
    t_sat();
    finish_run();
  end
endmodule